// File: doc/BRIEF.md
# Mux-Based Ripple Carry Adder

This block adds two unsigned operands and a carry-in. It builds the carry path the way a lookup-table fabric does. Each bit position first forms a propagate flag, the exclusive-OR of its two operand bits. A dedicated 2:1 carry multiplexer then picks the carry for the next position. When propagate is high it forwards the incoming carry. When propagate is low it forwards the operand bit, which in that case is the generate value. The sum bit is propagate XOR the incoming carry.

The carry travels directly from one bit cell to the next through these multiplexers; no sum-of-products carry equation is formed. The width is a parameter. A second parameter adds an output register stage with a synchronous reset. With that stage, the sum and carry-out of an operand set appear one clock after it is presented. Without it, the block is purely combinational.

Top module: `mux_carry_adder`

## Requirements
- R1: `sumOut` equals the low WIDTH bits of opA + opB + carryIn, treated as unsigned numbers.
- R2: `carryOut` equals bit WIDTH of opA + opB + carryIn, which is the carry-mux output of the most significant cell. In any cell whose two operand bits agree, the carry leaving that cell equals that operand bit.
- R3: When every bit position propagates (opB is the bitwise complement of opA), `carryOut` equals `carryIn`. All ones plus zero plus a carry-in of 1 gives a sum of zero and a carry-out of 1.
- R4: Zero plus zero with a carry-in of 1 gives a sum of 1 and a carry-out of 0. All ones plus all ones with a carry-in of 0 gives a sum of all ones except bit 0, and a carry-out of 1.
- R5: With OUT_REG = 1, the result for the operands sampled at a rising clock edge is presented after that edge and holds for one full cycle. With OUT_REG = 0, the result follows the operands with no clock.
- R6: With OUT_REG = 1, a rising edge with `rst` high clears both `sumOut` and `carryOut` to 0, whatever the operands are.
- R7: The width WIDTH may be any value of 1 or more. A 1-bit instance without the output register produces the correct two-bit result for all eight input combinations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous reset for the output register, active high |
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | WIDTH | Sum bits |
| carryOut | output | 1 | Carry out of the most significant bit |

## Verification
A wrong propagate flag or a wrong mux select in one cell changes that cell's sum bit. It also changes the carry into every higher cell. So the fault shows at the ports as a wrong sum or carry-out for any operand pair that drives a carry through that position, in the very cycle the result is presented (one clock after the operands when the register is present). Long ripples are the harshest test: all ones plus a carry-in, and complementary operands, pass the carry through every mux. A broken link anywhere in the chain then corrupts the carry-out at once. A reset fault shows as a non-zero output on the first cycle after a reset edge.

// File: rtl/carry_chain_pkg.sv
`timescale 1ns/1ps
package carry_chain_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture the adder result into the output stage
    logic clear;  // force the output stage to zero
  } stageCtrl_t;

endpackage

// File: rtl/carry_mux_cell.sv
`timescale 1ns/1ps
// One bit slice: function-generator stage (propagate) plus dedicated carry mux.
module carry_mux_cell (
  input  logic aBit,
  input  logic bBit,
  input  logic cIn,
  output logic sBit,
  output logic cOut
);

  logic prop;

  // function-generator stage
  assign prop = aBit ^ bBit;

  // dedicated carry mux: propagate selects the incoming carry,
  // otherwise the operand bit acts as generate
  always_comb begin
    if (prop) cOut = cIn;
    else      cOut = aBit;
  end

  assign sBit = prop ^ cIn;

  // R2: matching operand bits force the outgoing carry to that bit value
  always_comb begin
    if (aBit == bBit) begin
      a_r2_gen_value: assert (cOut == bBit)
        else $error("carry mux ignored generate value");
    end
  end

endmodule

// File: rtl/carry_chain_ctrl.sv
`timescale 1ns/1ps
// Turns the reset pin into strobes for the output stage.
module carry_chain_ctrl
  import carry_chain_pkg::*;
(
  input  logic       rst,
  output stageCtrl_t ctrl
);

  always_comb begin
    ctrl.clear = rst;
    ctrl.load  = ~rst;
  end

endmodule

// File: rtl/carry_chain_datapath.sv
`timescale 1ns/1ps
// Chain of mux cells plus an optional output register stage.
module carry_chain_datapath
  import carry_chain_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  stageCtrl_t       ctrl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);

  localparam int RES_W = WIDTH + 1;

  logic [WIDTH:0]   carryLink;
  logic [WIDTH-1:0] sumComb;

  assign carryLink[0] = carryIn;

  // direct cell-to-cell carry links, no general routing in between
  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    carry_mux_cell u_cell (
      .aBit (opA[i]),
      .bBit (opB[i]),
      .cIn  (carryLink[i]),
      .sBit (sumComb[i]),
      .cOut (carryLink[i+1])
    );
  end

  // arithmetic view used only by the checks
  logic [RES_W-1:0] arithRef;
  assign arithRef = RES_W'(opA) + RES_W'(opB) + RES_W'(carryIn);

  // R1 / R2: chain result matches binary addition
  always_comb begin
    a_r1_chain_sum: assert ({carryLink[WIDTH], sumComb} == arithRef)
      else $error("mux chain disagrees with addition");
  end

  // R3: a fully propagating chain returns the carry-in at the top
  always_comb begin
    if ((opA ^ opB) == {WIDTH{1'b1}}) begin
      a_r3_full_ripple: assert (carryLink[WIDTH] == carryIn)
        else $error("full ripple lost the carry");
    end
  end

  if (OUT_REG) begin : g_reg
    logic [WIDTH-1:0] sumQ;
    logic             carryQ;

    always_ff @(posedge clk) begin
      if (ctrl.clear) begin
        sumQ   <= '0;
        carryQ <= 1'b0;
      end else if (ctrl.load) begin
        sumQ   <= sumComb;
        carryQ <= carryLink[WIDTH];
      end
    end

    assign sumOut   = sumQ;
    assign carryOut = carryQ;

    // R5: one clock from operands to result
    a_r5_one_cycle: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> ({carryOut, sumOut} == $past(arithRef)))
      else $error("registered result is not last cycle's sum");

    // R6: a reset edge clears the outputs
    a_r6_reset_clear: assert property (@(posedge clk)
      rst |=> (sumOut == '0 && carryOut == 1'b0))
      else $error("outputs not cleared by reset");
  end else begin : g_comb
    assign sumOut   = sumComb;
    assign carryOut = carryLink[WIDTH];
  end

endmodule

// File: rtl/mux_carry_adder.sv
`timescale 1ns/1ps
// Top: ripple adder whose carry runs through propagate-controlled muxes.
module mux_carry_adder
  import carry_chain_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);

  stageCtrl_t stageCtrl;

  initial begin
    a_r7_width_ok: assert (WIDTH >= 1) else $error("WIDTH must be at least 1");
  end

  carry_chain_ctrl u_ctrl (
    .rst  (rst),
    .ctrl (stageCtrl)
  );

  carry_chain_datapath #(
    .WIDTH   (WIDTH),
    .OUT_REG (OUT_REG)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (stageCtrl),
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .sumOut   (sumOut),
    .carryOut (carryOut)
  );

endmodule

// File: tb/mux_carry_adder_test.sv
`timescale 1ns/1ps
module mux_carry_adder_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         carryIn = 1'b0;
  logic [W-1:0] sumOut;
  logic         carryOut;

  // narrow combinational instance for R7 and the unregistered R5 variant
  logic nA = 1'b0, nB = 1'b0, nC = 1'b0;
  logic nSum, nCarry;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 1'b0;

  // reference model state: the result expected after the next edge
  logic [W:0] expNext;
  string      tagNext;
  bit         expValid = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  mux_carry_adder #(.WIDTH(W), .OUT_REG(1'b1)) uut (
    .clk (clk), .rst (rst), .opA (opA), .opB (opB), .carryIn (carryIn),
    .sumOut (sumOut), .carryOut (carryOut)
  );

  mux_carry_adder #(.WIDTH(1), .OUT_REG(1'b0)) uutNarrow (
    .clk (clk), .rst (1'b0), .opA (nA), .opB (nB), .carryIn (nC),
    .sumOut (nSum), .carryOut (nCarry)
  );

  task automatic compare(input string tag, input logic [W:0] act, input logic [W:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: check the result of the previous vector, then drive a new one
  task automatic step(input logic r, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic c, input string tag);
    @(negedge clk);
    if (expValid) compare(tagNext, {carryOut, sumOut}, expNext);
    rst = r; opA = a; opB = b; carryIn = c;
    if (r) begin
      expNext = '0;
      tagNext = "R6 reset clears";
    end else begin
      expNext = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
      tagNext = tag;
    end
    expValid = 1'b1;
  endtask

  initial begin
    // reset with busy operands: R6
    step(1'b1, 8'hFF, 8'hFF, 1'b1, "R6");
    step(1'b1, 8'hA5, 8'h5A, 1'b1, "R6");
    // corners
    step(1'b0, 8'hFF, 8'h00, 1'b1, "R3 all ones plus carry-in");
    step(1'b0, 8'h00, 8'h00, 1'b1, "R4 zero plus carry-in");
    step(1'b0, 8'hFF, 8'hFF, 1'b0, "R4 all ones twice");
    step(1'b0, 8'hA5, 8'h5A, 1'b1, "R3 complementary with carry");
    step(1'b0, 8'h5A, 8'hA5, 1'b0, "R3 complementary no carry");
    step(1'b0, 8'h00, 8'h00, 1'b0, "R1 zero");
    step(1'b0, 8'h80, 8'h80, 1'b0, "R2 top generate");
    step(1'b0, 8'h7F, 8'h01, 1'b0, "R1 long ripple");
    step(1'b0, 8'hFF, 8'hFF, 1'b1, "R2 max sum");
    // R5: distinct back-to-back vectors, each seen exactly one cycle later
    for (int i = 0; i < 300; i++) begin
      step(1'b0, 8'($urandom), 8'($urandom), 1'($urandom), "R1/R2/R5 random");
    end
    // mid-run reset then recovery
    step(1'b1, 8'hFF, 8'h01, 1'b1, "R6");
    step(1'b0, 8'h12, 8'h34, 1'b1, "R5 after reset");
    step(1'b0, 8'hFF, 8'h00, 1'b1, "R3 after reset");
    step(1'b0, 8'h00, 8'h00, 1'b0, "R1 drain");
    @(negedge clk);
    compare(tagNext, {carryOut, sumOut}, expNext);

    // R7: exhaustive 1-bit combinational instance, R5 unregistered path
    for (int v = 0; v < 8; v++) begin
      nA = v[0]; nB = v[1]; nC = v[2];
      #1;
      compare("R7 one-bit width / R5 no register", {8'b0, nCarry, nSum},
              {8'b0, 2'(int'(v[0]) + int'(v[1]) + int'(v[2]))});
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule